// File: doc/BRIEF.md
# Banked File-Register Rotate and Fill Executor

This block carries out two byte-wide data-memory instructions for a small 8-bit core. One rotates a byte right by one place, with the low bit wrapping round to the top. The other fills a byte with all ones. The block takes a 16-bit instruction word together with a one-cycle start pulse. It then runs a fixed four-step sequence: decode, read, process and write. A simple synchronous port drives the external data memory. The block also holds the working register W and the negative (N) and zero (Z) flags.

The 12-bit data address comes from an 8-bit file field in the instruction and a 4-bit bank register input. An access-bank bit in the instruction selects how they combine. With the bit clear, the bank register is ignored and the file field maps into the shared access window. The lower half of that window sits at the bottom of data memory and the upper half at the top. A destination bit in the rotate instruction sends the result either to W or back to the same memory byte. The fill instruction always writes memory and never touches the flags. Any other word runs the same four steps without reading, writing or changing state.

Top module: `fileop_exec`

## Requirements
- R1: The decode recognises two formats. Rotate is instr[15:10]=010000, with destination bit d=instr[9], access bit a=instr[8] and file field f=instr[7:0]. Fill is instr[15:9]=0110100, with a=instr[8] and f=instr[7:0].
- R2: Rotate produces {v[0], v[7:1]} from the byte v read from memory. For example, D7h becomes EBh.
- R3: For rotate with d=0, W takes the result and no memory write occurs. With d=1, the result is written back to the same address and W is unchanged.
- R4: After a rotate, N equals bit 7 of the result and Z is 1 exactly when the result is 00h.
- R5: Fill writes FFh to the addressed byte and leaves N, Z and W unchanged.
- R6: With a=1 the address is {bankSel, f}. With a=0 it is 000h+f when f<80h and F00h+f when f>=80h. The same address is used for the read and the write.
- R7: A start pulse seen while idle begins a four-cycle sequence, and busy is high for those four cycles. memRe is high only in the second cycle. memWe is high only in the fourth cycle. The write data is valid in the same cycle as memWe.
- R8: Fill still issues its memory read in the second cycle, and the value read is discarded.
- R9: A word matching neither format issues no read and no write, and leaves W, N and Z unchanged. It still takes four busy cycles and produces a done pulse.
- R10: done is high for exactly one cycle, the cycle after the fourth step. W and the flags show their new values in that cycle. A start pulse that arrives while busy is ignored, and a start pulse in the done cycle is accepted.
- R11: After reset, W=00h, N=0, Z=0, and busy, done, memRe and memWe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an instruction when idle |
| instr | input | 16 | Instruction word, sampled with start |
| bankSel | input | 4 | Bank register value, used when a=1 |
| memRdata | input | 8 | Memory read data, valid the cycle after memRe |
| memAddr | output | 12 | Memory address |
| memRe | output | 1 | Memory read request |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 8 | Memory write data |
| wReg | output | 8 | Working register W |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase or a wrong latched opcode shows up within one clock as a misplaced memRe, memWe or busy edge, because the bench compares these strobes against its model on every cycle. A wrong address mapping or a wrong latched file field appears on memAddr during the read cycle, and again on the write cycle. A fault in the result, W or the flags becomes visible on memWdata in the fourth cycle, or on wReg, flagN and flagZ in the done cycle. A final sweep of the whole memory then catches stray or missing writes.

// File: rtl/fileop_pkg.sv
package fileop_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEC,
    PH_RD,
    PH_PROC,
    PH_WR
  } phase_t;

  typedef enum logic [1:0] {
    OP_NOP,
    OP_ROR,
    OP_FILL
  } op_t;

  // strobes handed from the sequencer to the datapath
  typedef struct packed {
    logic loadInstr;
    logic loadAddr;
    logic readEn;
    logic loadResult;
    logic writeEn;
    logic commitW;
    logic commitFlags;
    logic isRot;
  } strobe_t;

  localparam logic [5:0] ROR_OPCODE  = 6'b010000;
  localparam logic [6:0] FILL_OPCODE = 7'b0110100;

endpackage

// File: rtl/fileop_ctrl.sv
module fileop_ctrl
  import fileop_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int FILE_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instrQ,
  output strobe_t            strobes,
  output logic               busy,
  output logic               done
);

  localparam int DEST_BIT = FILE_W + 1;

  phase_t phase;
  op_t    opQ;
  op_t    opDec;
  logic   destMemQ;

  // decode of the latched word, used in the decode phase
  always_comb begin
    if (instrQ[INSTR_W-1 -: 6] == ROR_OPCODE)
      opDec = OP_ROR;
    else if (instrQ[INSTR_W-1 -: 7] == FILL_OPCODE)
      opDec = OP_FILL;
    else
      opDec = OP_NOP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      opQ      <= OP_NOP;
      destMemQ <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= (phase == PH_WR);
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_DEC;
        PH_DEC: begin
          opQ      <= opDec;
          destMemQ <= instrQ[DEST_BIT];
          phase    <= PH_RD;
        end
        PH_RD:   phase <= PH_PROC;
        PH_PROC: phase <= PH_WR;
        PH_WR:   phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.loadInstr   = (phase == PH_IDLE) && start;
    strobes.loadAddr    = (phase == PH_DEC);
    strobes.readEn      = (phase == PH_RD) && (opQ != OP_NOP);
    strobes.loadResult  = (phase == PH_PROC);
    strobes.writeEn     = (phase == PH_WR) &&
                          ((opQ == OP_FILL) || ((opQ == OP_ROR) && destMemQ));
    strobes.commitW     = (phase == PH_WR) && (opQ == OP_ROR) && !destMemQ;
    strobes.commitFlags = (phase == PH_WR) && (opQ == OP_ROR);
    strobes.isRot       = (opQ == OP_ROR);
  end

  assign busy = (phase != PH_IDLE);

  // R7
  rd_follows_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DEC) |=> (phase == PH_RD));

  // R7
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeEn |-> $past(strobes.readEn, 2));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phase != PH_WR) |=> busy);

endmodule

// File: rtl/fileop_dpath.sv
module fileop_dpath
  import fileop_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int FILE_W  = 8,
  parameter int BANK_W  = 4,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [INSTR_W-1:0]        instr,
  input  logic [BANK_W-1:0]         bankSel,
  input  strobe_t                   strobes,
  input  logic [DATA_W-1:0]         memRdata,
  output logic [INSTR_W-1:0]        instrQ,
  output logic [BANK_W+FILE_W-1:0]  memAddr,
  output logic                      memRe,
  output logic                      memWe,
  output logic [DATA_W-1:0]         memWdata,
  output logic [DATA_W-1:0]         wReg,
  output logic                      flagN,
  output logic                      flagZ
);

  localparam int ADDR_W     = BANK_W + FILE_W;
  localparam int ACCESS_BIT = FILE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] resultQ;
  logic [DATA_W-1:0] resultNext;
  logic [FILE_W-1:0] fileField;

  assign fileField = instrQ[FILE_W-1:0];

  // bank mapping: bank register, or split access window
  always_comb begin
    if (instrQ[ACCESS_BIT])
      addrNext = {bankSel, fileField};
    else if (fileField[FILE_W-1])
      addrNext = {{BANK_W{1'b1}}, fileField};
    else
      addrNext = {{BANK_W{1'b0}}, fileField};
  end

  always_comb begin
    if (strobes.isRot)
      resultNext = {memRdata[0], memRdata[DATA_W-1:1]};
    else
      resultNext = '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrQ  <= '0;
      addrQ   <= '0;
      resultQ <= '0;
      wReg    <= '0;
      flagN   <= 1'b0;
      flagZ   <= 1'b0;
    end else begin
      if (strobes.loadInstr)  instrQ  <= instr;
      if (strobes.loadAddr)   addrQ   <= addrNext;
      if (strobes.loadResult) resultQ <= resultNext;
      if (strobes.commitW)    wReg    <= resultQ;
      if (strobes.commitFlags) begin
        flagN <= resultQ[DATA_W-1];
        flagZ <= (resultQ == '0);
      end
    end
  end

  assign memAddr  = addrQ;
  assign memRe    = strobes.readEn;
  assign memWe    = strobes.writeEn;
  assign memWdata = resultQ;

  // R2
  ror_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadResult && strobes.isRot) |=>
      (resultQ == {$past(memRdata[0]), $past(memRdata[DATA_W-1:1])}));

  // R4
  flag_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitFlags |=>
      (flagN == resultQ[DATA_W-1]) && (flagZ == (resultQ == '0)));

  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commitFlags |=> ($stable(flagN) && $stable(flagZ)));

  // R3
  w_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commitW |=> $stable(wReg));

  // R6
  addr_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr == $past(memAddr, 2)));

endmodule

// File: rtl/fileop_exec.sv
module fileop_exec
  import fileop_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int FILE_W  = 8,
  parameter int BANK_W  = 4,
  parameter int DATA_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [INSTR_W-1:0]       instr,
  input  logic [BANK_W-1:0]        bankSel,
  input  logic [DATA_W-1:0]        memRdata,
  output logic [BANK_W+FILE_W-1:0] memAddr,
  output logic                     memRe,
  output logic                     memWe,
  output logic [DATA_W-1:0]        memWdata,
  output logic [DATA_W-1:0]        wReg,
  output logic                     flagN,
  output logic                     flagZ,
  output logic                     busy,
  output logic                     done
);

  strobe_t            strobes;
  logic [INSTR_W-1:0] instrQ;

  fileop_ctrl #(
    .INSTR_W(INSTR_W),
    .FILE_W (FILE_W)
  ) ctrlInst (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .instrQ (instrQ),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  fileop_dpath #(
    .INSTR_W(INSTR_W),
    .FILE_W (FILE_W),
    .BANK_W (BANK_W),
    .DATA_W (DATA_W)
  ) dpathInst (
    .clk     (clk),
    .rstN    (rstN),
    .instr   (instr),
    .bankSel (bankSel),
    .strobes (strobes),
    .memRdata(memRdata),
    .instrQ  (instrQ),
    .memAddr (memAddr),
    .memRe   (memRe),
    .memWe   (memWe),
    .memWdata(memWdata),
    .wReg    (wReg),
    .flagN   (flagN),
    .flagZ   (flagZ)
  );

endmodule

// File: tb/fileop_exec_test.sv
module fileop_exec_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  bankSel = '0;
  logic [7:0]  memRdata = '0;
  logic [11:0] memAddr;
  logic        memRe, memWe;
  logic [7:0]  memWdata, wReg;
  logic        flagN, flagZ, busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  fileop_exec uut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .bankSel(bankSel),
    .memRdata(memRdata), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .wReg(wReg), .flagN(flagN), .flagZ(flagZ),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // external memory attached to the block
  logic [7:0] mem [4096];
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  // reference model
  logic [7:0]  refMem [4096];
  int          mPhase = 0;
  int          eKind = 0;
  bit          eDest = 0;
  bit          eWrites = 0;
  logic [11:0] eAddr = '0;
  logic [7:0]  eRes = '0;
  logic [7:0]  eW = '0;
  bit          eN = 0, eZ = 0, eDone = 0;

  function automatic int kindOf(logic [15:0] w);
    if (w[15:10] == 6'b010000) return 1;
    if (w[15:9] == 7'b0110100) return 2;
    return 0;
  endfunction

  function automatic logic [11:0] addrOf(logic [15:0] w, logic [3:0] b);
    if (w[8]) return {b, w[7:0]};
    if (w[7:0] >= 8'h80) return 12'hF00 + {4'h0, w[7:0]};
    return {4'h0, w[7:0]};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; eW = '0; eN = 0; eZ = 0; eDone = 0; eKind = 0; eWrites = 0;
    end else if (mPhase == 4) begin
      if (eKind == 1 && !eDest) eW = eRes;
      if (eKind == 1) begin eN = eRes[7]; eZ = (eRes == 8'h00); end
      if (eWrites) refMem[eAddr] = eRes;
      eDone = 1;
      mPhase = 0;
    end else begin
      eDone = 0;
      if (mPhase == 0) begin
        if (start) begin
          eKind = kindOf(instr);
          eDest = instr[9];
          eAddr = addrOf(instr, bankSel);
          eRes = (eKind == 1) ? {refMem[eAddr][0], refMem[eAddr][7:1]} : 8'hFF;
          eWrites = (eKind == 2) || (eKind == 1 && eDest);
          mPhase = 1;
        end
      end else begin
        mPhase = mPhase + 1;
      end
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(busy == (mPhase != 0), "R7 busy", busy, mPhase != 0);
      check(memRe == (mPhase == 2 && eKind != 0), "R8/R9 read strobe R8 R9", memRe,
            mPhase == 2 && eKind != 0);
      check(memWe == (mPhase == 4 && eWrites), "R3 write strobe", memWe,
            mPhase == 4 && eWrites);
      if (memRe) check(memAddr == eAddr, "R6 read address", memAddr, eAddr);
      if (memWe) begin
        check(memAddr == eAddr, "R6 write address", memAddr, eAddr);
        check(memWdata == eRes, "R2/R5 write data R2 R5", memWdata, eRes);
      end
      check(done == eDone, "R10 done", done, eDone);
      check(wReg == eW, "R3 W", wReg, eW);
      check(flagN == eN, "R4 N", flagN, eN);
      check(flagZ == eZ, "R4 Z", flagZ, eZ);
    end
  end

  task automatic runInstr(logic [15:0] w, logic [3:0] b);
    @(negedge clk);
    bankSel = b; instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'((i * 37 + 5) & 255);
      refMem[i] = mem[i];
    end
    mem[12'h025] = 8'hD7; refMem[12'h025] = 8'hD7;
    mem[12'h200] = 8'h00; refMem[12'h200] = 8'h00;
    mem[12'hF90] = 8'h01; refMem[12'hF90] = 8'h01;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(wReg == 8'h00 && !flagN && !flagZ, "R11 reset W/flags", {wReg, flagN, flagZ}, 0);
    check(!busy && !done && !memRe && !memWe, "R11 reset strobes",
          {busy, done, memRe, memWe}, 0);
    rstN = 1'b1;

    // R1 R2 R3 rotate to memory, access low half
    runInstr({6'b010000, 1'b1, 1'b0, 8'h25}, 4'h7);
    check(done == 1'b1, "R10 done after four steps", done, 1);
    @(negedge clk);
    check(mem[12'h025] == 8'hEB, "R2 rotate D7", mem[12'h025], 8'hEB);
    // R3 rotate to W, memory kept
    runInstr({6'b010000, 1'b0, 1'b0, 8'h25}, 4'h7);
    check(wReg == 8'hF5, "R3 W gets result", wReg, 8'hF5);
    check(flagN == 1'b1 && flagZ == 1'b0, "R4 negative", {flagN, flagZ}, 2'b10);
    @(negedge clk);
    check(mem[12'h025] == 8'hEB, "R3 memory unchanged", mem[12'h025], 8'hEB);
    // R6 banked and upper access half
    runInstr({6'b010000, 1'b1, 1'b1, 8'h10}, 4'h3);
    runInstr({6'b010000, 1'b0, 1'b0, 8'h90}, 4'h3);
    check(wReg == 8'h80, "R6 upper access F90", wReg, 8'h80);
    // R4 zero result
    runInstr({6'b010000, 1'b0, 1'b1, 8'h00}, 4'h2);
    check(flagZ == 1'b1 && flagN == 1'b0, "R4 zero", {flagN, flagZ}, 2'b01);
    // R5 R8 fill keeps flags
    runInstr({7'b0110100, 1'b1, 8'h44}, 4'h5);
    check(flagZ == 1'b1 && wReg == 8'h00, "R5 flags and W kept", {wReg, flagZ}, 9'h001);
    runInstr({7'b0110100, 1'b0, 8'hC0}, 4'h5);
    @(negedge clk);
    check(mem[12'h544] == 8'hFF && mem[12'hFC0] == 8'hFF, "R5 fill FF",
          {mem[12'h544], mem[12'hFC0]}, 16'hFFFF);
    // R9 unrecognised words
    runInstr(16'hFFFF, 4'h1);
    check(done == 1'b1, "R9 nop done", done, 1);
    runInstr(16'h0000, 4'h1);
    runInstr({6'b010001, 10'h0AA}, 4'h1);
    // R10 start while busy is ignored
    @(negedge clk);
    bankSel = 4'h6; instr = {6'b010000, 1'b1, 1'b1, 8'h33}; start = 1'b1;
    @(negedge clk);
    instr = {7'b0110100, 1'b1, 8'h34};
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk); @(negedge clk);
    check(done == 1'b1, "R10 done with held start", done, 1);
    // R10 start in done cycle accepted
    bankSel = 4'h6; instr = {7'b0110100, 1'b1, 8'h35}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 back-to-back accepted", busy, 1);
    repeat (4) @(negedge clk);
    // mixed patterns
    for (int n = 0; n < 300; n++) begin
      logic [15:0] w;
      int sel;
      sel = $urandom_range(0, 3);
      w = 16'($urandom);
      if (sel == 0) w[15:10] = 6'b010000;
      else if (sel == 1) w[15:9] = 7'b0110100;
      else if (sel == 2) w[15:10] = 6'b010000;
      runInstr(w, 4'($urandom));
    end
    @(negedge clk); @(negedge clk);
    begin
      int miss = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] !== refMem[i]) miss++;
      check(miss == 0, "R3 R5 memory contents", miss, 0);
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule